// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address by reading translation entries from memory. A request carries the linear address and three attributes: write, user-mode and instruction fetch. The walker first reads a directory entry. The directory base input and the top ten address bits locate that entry. The entry either maps a 4 MiB region directly or points to a second-level table. When it points to a table, the walker reads a table entry, which maps a 4 KiB page.

The walker checks presence, reserved bits and access rights. On success it writes back entries whose accessed or dirty flags change, then returns the physical address. On a failure it returns a five-bit error code and the page-fault vector. It also latches the faulting linear address in a register that holds its value until the next fault.

Memory is reached through a simple word port. A read strobe returns data one cycle later, and a write strobe takes effect at the clock edge. The walker handles one request at a time and accepts a new one only while idle.

Top module: `pt_walker`

## Requirements
- R1: With 4 KiB mapping, the directory entry is read at {dir_base_i[31:12], va[31:22], 2'b00}. The table entry is read at {pde[31:12], va[21:12], 2'b00}. The result is {pte[31:12], va[11:0]}.
- R2: When super_en_i is 1 and the directory entry has P (bit 0) and PS (bit 7) set, the result is {pde[31:22], va[21:0]} and no table is read. When super_en_i is 0, bit 7 is ignored and the entry points to a table.
- R3: An entry with P (bit 0) clear, at either level, gives a fault whose error code has bit 0 cleared.
- R4: A super-page directory entry with any of bits 21:13 set gives a fault with error bits 3 (reserved) and 0 both set. Error bit 3 is never set without bit 0.
- R5: A user access faults when U/S (bit 2) is 0 at any level. A user write faults when R/W (bit 1) is 0 at any level. Supervisor accesses ignore both bits. Rights faults set error bit 0.
- R6: Error code bit 1 equals the write attribute, bit 2 the user attribute and bit 4 the fetch attribute.
- R7: On success, Accessed (bit 5) is set in every entry used. Dirty (bit 6) is set only in the final mapping entry, and only for a write. A fault leaves every entry unchanged.
- R8: On a fault, fault_addr_o takes the linear address and holds it until the next fault. resp_vector_o is 14 on a fault response and 0 otherwise.
- R9: resp_valid_o is a one-cycle pulse. Counting clock edges after the accepting edge, it arrives after 2 edges for a directory-level fault, 3 for a super page, 4 for a table-level fault and 6 for a 4 KiB success. req_ready_o is high only when idle.
- R10: After reset: req_ready_o=1, resp_valid_o=0, mem_rd_o=0, mem_we_o=0, fault_addr_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| dir_base_i | input | 32 | Directory base, bits 31:12 used |
| super_en_i | input | 1 | Enables 4 MiB directory mappings |
| resp_valid_o | output | 1 | Response pulse |
| resp_paddr_o | output | 32 | Physical address (success) |
| resp_fault_o | output | 1 | Translation failed |
| resp_err_o | output | 5 | Fault error code |
| resp_vector_o | output | 8 | 14 on fault, else 0 |
| fault_addr_o | output | 32 | Last faulting linear address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write-back entry |
| mem_rdata_i | input | 32 | Read data, one cycle after strobe |

## Verification
Some cases can only be reached by first placing entries in memory. These include a rights fault that comes only from the directory level while the table entry permits the access, and a directory entry with bit 7 set that must act as a pointer when super pages are off. The bench builds a small directory and a shared table in which one pointer entry denies user access. It then reaches the same table entries through different directory slots and attribute mixes. A behavioural model predicts, for every cycle, whether a response is due, and predicts each entry's value after write-back. Entries touched by earlier walks give later walks pre-set accessed and dirty bits.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned SUP_OFF_W = OFF_W + IDX_W;
  localparam int unsigned ERR_W     = 5;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned B_P  = 0;
  localparam int unsigned B_RW = 1;
  localparam int unsigned B_US = 2;
  localparam int unsigned B_A  = 5;
  localparam int unsigned B_D  = 6;
  localparam int unsigned B_PS = 7;
  localparam logic [VEC_W-1:0] PF_VEC = VEC_W'(14);

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_CHK, S_TBL_RD, S_TBL_CHK, S_WB_DIR, S_WB_TBL, S_RESP
  } walk_st_e;
endpackage

// File: rtl/pw_entry_chk.sv
module pw_entry_chk
  import pw_pkg::*;
(
  input  logic [VA_W-1:0]  entry_i,
  input  logic             is_dir_i,
  input  logic             super_en_i,
  input  logic             up_us_i,
  input  logic             up_rw_i,
  input  logic             acc_wr_i,
  input  logic             acc_user_i,
  input  logic             acc_fetch_i,
  output logic             leaf_o,
  output logic             fault_o,
  output logic [ERR_W-1:0] err_o
);
  logic present, is_super, rsvd, us_eff, rw_eff, prot;

  always_comb begin
    present  = entry_i[B_P];
    is_super = is_dir_i & super_en_i & entry_i[B_PS];
    leaf_o   = ~is_dir_i | is_super;
    rsvd     = is_super & (|entry_i[SUP_OFF_W-1:OFF_W+1]);
    us_eff   = up_us_i & entry_i[B_US];
    rw_eff   = up_rw_i & entry_i[B_RW];
    // rights are judged only at the final mapping, with rights of all levels combined
    prot     = acc_user_i & (~us_eff | (acc_wr_i & ~rw_eff));
    fault_o  = ~present | (leaf_o & (rsvd | prot));
    err_o    = {acc_fetch_i, present & rsvd, acc_user_i, acc_wr_i, present};
  end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
(
  input  logic [VA_W-1:0] dir_base_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [VA_W-1:0] pde_i,
  input  logic [VA_W-1:0] pte_i,
  output logic [VA_W-1:0] dir_addr_o,
  output logic [VA_W-1:0] tbl_addr_o,
  output logic [VA_W-1:0] page_pa_o,
  output logic [VA_W-1:0] super_pa_o
);
  localparam int unsigned WORD_SH = 2;

  always_comb begin
    dir_addr_o = {dir_base_i[VA_W-1:OFF_W], vaddr_i[VA_W-1:SUP_OFF_W], {WORD_SH{1'b0}}};
    tbl_addr_o = {pde_i[VA_W-1:OFF_W], vaddr_i[SUP_OFF_W-1:OFF_W], {WORD_SH{1'b0}}};
    page_pa_o  = {pte_i[VA_W-1:OFF_W], vaddr_i[OFF_W-1:0]};
    super_pa_o = {pde_i[VA_W-1:SUP_OFF_W], vaddr_i[SUP_OFF_W-1:0]};
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [31:0]      req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  input  logic             req_fetch_i,
  input  logic [31:0]      dir_base_i,
  input  logic             super_en_i,
  output logic             resp_valid_o,
  output logic [31:0]      resp_paddr_o,
  output logic             resp_fault_o,
  output logic [4:0]       resp_err_o,
  output logic [7:0]       resp_vector_o,
  output logic [31:0]      fault_addr_o,
  output logic             mem_rd_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i
);
  walk_st_e           state_q;
  logic [VA_W-1:0]    va_q, base_q, pde_q, pte_q, paddr_q, fault_addr_q;
  logic               wr_q, user_q, fetch_q, sup_en_q, super_q, fault_q;
  logic [ERR_W-1:0]   err_q;

  logic [VA_W-1:0]    dir_addr, tbl_addr, page_pa, super_pa, new_pde, new_pte;
  logic               chk_leaf, chk_fault, chk_is_dir;
  logic [ERR_W-1:0]   chk_err;

  assign chk_is_dir = (state_q == S_DIR_CHK);

  pw_addr_gen u_addr (
    .dir_base_i (base_q),
    .vaddr_i    (va_q),
    .pde_i      (pde_q),
    .pte_i      (pte_q),
    .dir_addr_o (dir_addr),
    .tbl_addr_o (tbl_addr),
    .page_pa_o  (page_pa),
    .super_pa_o (super_pa)
  );

  pw_entry_chk u_chk (
    .entry_i     (mem_rdata_i),
    .is_dir_i    (chk_is_dir),
    .super_en_i  (sup_en_q),
    .up_us_i     (chk_is_dir | pde_q[B_US]),
    .up_rw_i     (chk_is_dir | pde_q[B_RW]),
    .acc_wr_i    (wr_q),
    .acc_user_i  (user_q),
    .acc_fetch_i (fetch_q),
    .leaf_o      (chk_leaf),
    .fault_o     (chk_fault),
    .err_o       (chk_err)
  );

  always_comb begin
    new_pde = pde_q;
    new_pde[B_A] = 1'b1;
    if (super_q && wr_q) new_pde[B_D] = 1'b1;
    new_pte = pte_q;
    new_pte[B_A] = 1'b1;
    if (wr_q) new_pte[B_D] = 1'b1;
  end

  always_comb begin
    mem_rd_o    = (state_q == S_DIR_RD) || (state_q == S_TBL_RD);
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_DIR_RD: mem_addr_o = dir_addr;
      S_TBL_RD: mem_addr_o = tbl_addr;
      S_WB_DIR: begin
        mem_addr_o  = dir_addr;
        mem_wdata_o = new_pde;
        mem_we_o    = (new_pde != pde_q);
      end
      S_WB_TBL: begin
        mem_addr_o  = tbl_addr;
        mem_wdata_o = new_pte;
        mem_we_o    = (new_pte != pte_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      va_q         <= '0;
      base_q       <= '0;
      pde_q        <= '0;
      pte_q        <= '0;
      paddr_q      <= '0;
      fault_addr_q <= '0;
      wr_q         <= 1'b0;
      user_q       <= 1'b0;
      fetch_q      <= 1'b0;
      sup_en_q     <= 1'b0;
      super_q      <= 1'b0;
      fault_q      <= 1'b0;
      err_q        <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q     <= req_vaddr_i;
          base_q   <= dir_base_i;
          wr_q     <= req_write_i;
          user_q   <= req_user_i;
          fetch_q  <= req_fetch_i;
          sup_en_q <= super_en_i;
          super_q  <= 1'b0;
          fault_q  <= 1'b0;
          err_q    <= '0;
          paddr_q  <= '0;
          state_q  <= S_DIR_RD;
        end
        S_DIR_RD: state_q <= S_DIR_CHK;
        S_DIR_CHK: begin
          pde_q <= mem_rdata_i;
          if (chk_fault) begin
            fault_q      <= 1'b1;
            err_q        <= chk_err;
            fault_addr_q <= va_q;
            state_q      <= S_RESP;
          end else if (chk_leaf) begin
            super_q <= 1'b1;
            state_q <= S_WB_DIR;
          end else begin
            state_q <= S_TBL_RD;
          end
        end
        S_TBL_RD: state_q <= S_TBL_CHK;
        S_TBL_CHK: begin
          pte_q <= mem_rdata_i;
          if (chk_fault) begin
            fault_q      <= 1'b1;
            err_q        <= chk_err;
            fault_addr_q <= va_q;
            state_q      <= S_RESP;
          end else begin
            state_q <= S_WB_DIR;
          end
        end
        S_WB_DIR: begin
          paddr_q <= super_q ? super_pa : page_pa;
          state_q <= super_q ? S_RESP : S_WB_TBL;
        end
        S_WB_TBL: state_q <= S_RESP;
        S_RESP:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign resp_valid_o  = (state_q == S_RESP);
  assign resp_paddr_o  = paddr_q;
  assign resp_fault_o  = fault_q;
  assign resp_err_o    = err_q;
  assign resp_vector_o = (resp_valid_o && fault_q) ? PF_VEC : '0;
  assign fault_addr_o  = fault_addr_q;

  a_r9_resp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  a_r9_ready_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && (resp_valid_o || mem_rd_o || mem_we_o)));

  a_r4_rsvd_needs_p: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_err_o[3]) |-> (resp_err_o[0] && resp_fault_o));

  a_r3_np_only_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_fault_o) |-> (resp_err_o == '0));

  a_r7_wb_sets_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[B_A]);

  a_r7_no_dirty_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !wr_q && state_q == S_WB_TBL) |-> (mem_wdata_o[B_D] == pte_q[B_D]));

  a_r9_rd_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_we_o));

  a_r8_fault_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_DIR_CHK && state_q != S_TBL_CHK) |=> $stable(fault_addr_o));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_vaddr = '0, dir_base = '0;
  logic        super_en = 1'b0;
  logic        req_ready, resp_valid, resp_fault, mem_rd, mem_we;
  logic [31:0] resp_paddr, fault_addr, mem_addr, mem_wdata, mem_rdata;
  logic [4:0]  resp_err;
  logic [7:0]  resp_vector;

  logic [31:0] mem [0:2047];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] last_fault_va = '0;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user), .req_fetch_i(req_fetch),
    .dir_base_i(dir_base), .super_en_i(super_en),
    .resp_valid_o(resp_valid), .resp_paddr_o(resp_paddr), .resp_fault_o(resp_fault),
    .resp_err_o(resp_err), .resp_vector_o(resp_vector), .fault_addr_o(fault_addr),
    .mem_rd_o(mem_rd), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[12:2]];
    if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit w, input bit u, input bit f, input bit se);
    logic [31:0] pde, pte, pa, new_pde, new_pte, taddr;
    int pde_ix, pte_ix, lat;
    bit flt, tbl, us, rw, rsvd;
    logic [4:0] err;
    pde_ix = va[31:22]; pte_ix = 0; tbl = 0;
    pde = mem[pde_ix]; pte = '0; new_pde = pde; new_pte = '0;
    flt = 0; err = '0; pa = '0; lat = 0;
    if (!pde[0]) begin
      flt = 1; err = {f, 1'b0, u, w, 1'b0}; lat = 2;
    end else if (se && pde[7]) begin
      rsvd = |pde[21:13];
      if (rsvd || (u && (!pde[2] || (w && !pde[1])))) begin
        flt = 1; err = {f, rsvd, u, w, 1'b1}; lat = 2;
      end else begin
        pa = {pde[31:22], va[21:0]}; lat = 3;
        new_pde = pde | 32'h20 | (w ? 32'h40 : 32'h0);
      end
    end else begin
      tbl = 1;
      taddr = {pde[31:12], va[21:12], 2'b00};
      pte_ix = int'(taddr[12:2]);
      pte = mem[pte_ix]; new_pte = pte;
      us = pde[2] & pte[2]; rw = pde[1] & pte[1];
      if (!pte[0]) begin
        flt = 1; err = {f, 1'b0, u, w, 1'b0}; lat = 4;
      end else if (u && (!us || (w && !rw))) begin
        flt = 1; err = {f, 1'b0, u, w, 1'b1}; lat = 4;
      end else begin
        pa = {pte[31:12], va[11:0]}; lat = 6;
        new_pde = pde | 32'h20;
        new_pte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
      end
    end
    if (flt) last_fault_va = va;

    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready idle", {31'b0, req_ready}, 32'd1);
    req_vaddr = va; req_write = w; req_user = u; req_fetch = f; super_en = se;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      check(resp_valid == (k == lat), "R9 resp timing", {31'b0, resp_valid}, {31'b0, k == lat});
      if (k == lat) begin
        check(resp_fault == flt, "R3 R4 R5 fault flag", {31'b0, resp_fault}, {31'b0, flt});
        check(resp_err == err, "R6 error code", {27'b0, resp_err}, {27'b0, err});
        check(resp_vector == (flt ? 8'd14 : 8'd0), "R8 vector", {24'b0, resp_vector}, flt ? 32'd14 : 32'd0);
        if (!flt) check(resp_paddr == pa, "R1 R2 paddr", resp_paddr, pa);
      end
    end
    check(mem[pde_ix] == new_pde, "R7 dir entry update", mem[pde_ix], new_pde);
    if (tbl) check(mem[pte_ix] == new_pte, "R7 table entry update", mem[pte_ix], new_pte);
    check(fault_addr == last_fault_va, "R8 fault address", fault_addr, last_fault_va);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[1]       = 32'h0000_1007;
    mem[2]       = 32'h00C0_0087;
    mem[3]       = 32'h0100_2087;
    mem[4]       = 32'h0000_1003;
    mem[5]       = 32'h0000_1087;
    mem[1024+3]  = 32'hABCD_E007;
    mem[1024+4]  = 32'h1234_5005;
    mem[1024+5]  = 32'h0000_0000;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready && !resp_valid && !mem_rd && !mem_we && fault_addr == 0,
          "R10 reset", {27'b0, req_ready, resp_valid, mem_rd, mem_we, 1'b0}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    walk((32'd1 << 22) | (32'd3 << 12) | 32'h123, 0, 0, 0, 0); // R1 4K read, A set
    walk((32'd1 << 22) | (32'd3 << 12) | 32'h9A0, 1, 1, 0, 0); // R7 user write sets D
    walk((32'd1 << 22) | (32'd4 << 12) | 32'h0FF, 1, 1, 0, 0); // R5 user write to read-only
    walk((32'd1 << 22) | (32'd4 << 12) | 32'h0FF, 1, 0, 0, 0); // R5 supervisor write allowed
    walk((32'd1 << 22) | (32'd5 << 12), 0, 1, 1, 0);           // R3 table not present, R6 fetch
    walk(32'd6 << 22, 1, 0, 0, 1);                              // R3 directory not present
    walk((32'd2 << 22) | 32'h2ABCDE, 0, 1, 0, 1);               // R2 super read
    walk((32'd2 << 22) | 32'h000004, 1, 1, 0, 1);               // R2 R7 super write D in dir
    walk((32'd3 << 22) | 32'h10, 0, 0, 0, 1);                   // R4 reserved bits
    walk((32'd5 << 22) | (32'd3 << 12) | 32'h45, 0, 1, 0, 0);   // R2 PS ignored when disabled
    walk((32'd5 << 22) | 32'h345, 0, 0, 0, 1);                  // R2 same entry as super page
    walk((32'd4 << 22) | (32'd3 << 12), 0, 1, 1, 0);            // R5 directory denies user
    walk((32'd4 << 22) | (32'd3 << 12), 0, 0, 0, 0);            // R5 supervisor passes, R8 hold
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule